// File: doc/BRIEF.md
# I2C Configuration Register Slave

This block is an I2C target that holds sixteen 8-bit configuration registers and exposes all of them at once as a flat 128-bit image. The surrounding logic uses the image directly as control bits. A bus master programs the registers with ordinary I2C transfers.

SCL and SDA are synchronized into the system clock domain. The slave detects START, repeated START and STOP, and checks a 7-bit target address in which one bit follows a strap pin.

The first byte written after the address loads an internal register pointer. Every later byte, whether written or read, uses that pointer and then advances it, wrapping from 15 to 0. Each written byte lands in its register at the moment the slave acknowledges it. The SDA output is an open-drain pull-down enable.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The slave acknowledges (drives sda_pd_o high during the ninth SCL pulse) an address byte whose upper seven bits equal 1,0,1,1,A,0,0 (MSB first), where A is the level of addr_sel_i. The byte's LSB is R/W: 0 means write, 1 means read.
- R2: Any other address is not acknowledged, including the general-call address 0000000. Bytes that follow it up to the next START leave regs_o unchanged.
- R3: In a write, the first data byte sets the pointer to its low four bits. Each later byte is stored in register p, which appears on regs_o[8p+7:8p].
- R4: After each stored byte the pointer advances by one and wraps from 15 to 0, so a long write overwrites the earliest registers again.
- R5: A written byte is visible on regs_o from the clock on which the slave starts its acknowledge, before any STOP.
- R6: A byte cut short by STOP or by repeated START is discarded and changes no register.
- R7: After a repeated START with R/W=1, the slave sends register bytes MSB first, starting at the current pointer. The pointer advances after each byte and wraps modulo 16.
- R8: When the master answers a read byte with NACK, the slave releases SDA and drives nothing until the next START.
- R9: Reset clears all sixteen registers to 0x00 and releases SDA.
- R10: The slave changes sda_pd_o only while SCL is low, and it holds an acknowledge low for the whole high phase of the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level (resolved bus) |
| addr_sel_i | input | 1 | Strap that sets address bit A2 |
| regs_o | output | 128 | Register image, register n on bits [8n+7:8n] |
| sda_pd_o | output | 1 | Open-drain pull-down enable for SDA |

## Verification
The assertions check the following on every cycle:
- the slave pulls SDA only while the synchronized SCL is low;
- an acknowledge stays asserted while SCL is high in an acknowledge slot;
- an idle slave neither drives the line nor changes a register;
- any register change coincides with the slave's acknowledge.

Only the bench scenarios can show the rest. These are the address decode under both strap levels, pointer loading and wrap on long writes and reads, loss of truncated bytes on STOP and repeated START, and silence after a master NACK. Each is compared against a model of the register contents kept in the bench.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  localparam int unsigned NREG_DEF = 16;
  localparam int unsigned DW_DEF   = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } st_e;
endpackage

// File: rtl/i2c_cfg_line_sync.sv
module i2c_cfg_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s_o    = scl_pipe[STAGES-1];
  assign sda_s_o    = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_s_o & ~scl_q;
  assign scl_fall_o = ~scl_s_o & scl_q;
  // SDA edge while SCL stays high
  assign start_o    = scl_s_o & scl_q & sda_q & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_q & ~sda_q & sda_s_o;
endmodule

// File: rtl/i2c_cfg_regfile.sv
module i2c_cfg_regfile #(
  parameter int unsigned NREG = 16,
  parameter int unsigned DW   = 8,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [AW-1:0]      waddr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [AW-1:0]      raddr_i,
  output logic [DW-1:0]      rdata_o,
  output logic [NREG*DW-1:0] image_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             q <= '0;
      else if (we_i && waddr_i == AW'(g))      q <= wdata_i;
    end
    assign image_o[g*DW +: DW] = q;
  end

  assign rdata_o = image_o[raddr_i*DW +: DW];
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
  import i2c_cfg_pkg::*;
#(
  parameter int unsigned NREG      = NREG_DEF,
  parameter int unsigned DW        = DW_DEF,
  parameter logic [6:0]  ADDR_BASE = 7'b1011000,
  parameter int unsigned PIN_POS   = 2,
  localparam int unsigned AW       = $clog2(NREG),
  localparam int unsigned CW       = $clog2(DW + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               addr_sel_i,
  output logic [NREG*DW-1:0] regs_o,
  output logic               sda_pd_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  st_e           state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] shreg, tx;
  logic [AW-1:0] ptr;
  logic          rw, first, nack;
  logic [6:0]    dev_addr;
  logic [DW-1:0] rd_data;
  logic          we;
  logic          byte_end;

  i2c_cfg_line_sync u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_s_o(scl_s), .sda_s_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start), .stop_o(stop)
  );

  always_comb begin
    dev_addr          = ADDR_BASE;
    dev_addr[PIN_POS] = addr_sel_i;
  end

  assign byte_end = scl_fall && (cnt == CW'(DW));
  assign we       = (state == ST_WR) && byte_end && !first && !start && !stop;

  i2c_cfg_regfile #(.NREG(NREG), .DW(DW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(we), .waddr_i(ptr), .wdata_i(shreg),
    .raddr_i(ptr), .rdata_o(rd_data), .image_o(regs_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      tx       <= '0;
      ptr      <= '0;
      rw       <= 1'b0;
      first    <= 1'b0;
      nack     <= 1'b0;
      sda_pd_o <= 1'b0;
    end else if (start) begin
      state    <= ST_DEV;
      cnt      <= '0;
      sda_pd_o <= 1'b0;
    end else if (stop) begin
      state    <= ST_IDLE;
      sda_pd_o <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_DEV: begin
          if (scl_rise) begin
            shreg <= {shreg[DW-2:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (byte_end) begin
            if (shreg[7:1] == dev_addr) begin
              sda_pd_o <= 1'b1;
              rw       <= shreg[0];
              state    <= ST_DEV_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_DEV_ACK: if (scl_fall) begin
          cnt <= '0;
          if (rw) begin
            tx       <= rd_data;
            sda_pd_o <= ~rd_data[DW-1];
            state    <= ST_RD;
          end else begin
            sda_pd_o <= 1'b0;
            first    <= 1'b1;
            state    <= ST_WR;
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            shreg <= {shreg[DW-2:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (byte_end) begin
            sda_pd_o <= 1'b1;
            state    <= ST_WR_ACK;
            if (first) ptr <= shreg[AW-1:0];
            else       ptr <= ptr + 1'b1;
          end
        end
        ST_WR_ACK: if (scl_fall) begin
          sda_pd_o <= 1'b0;
          cnt      <= '0;
          first    <= 1'b0;
          state    <= ST_WR;
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (byte_end) begin
            sda_pd_o <= 1'b0;
            ptr      <= ptr + 1'b1;
            state    <= ST_RD_ACK;
          end else if (scl_fall) begin
            sda_pd_o <= ~tx[DW-2];
            tx       <= {tx[DW-2:0], 1'b0};
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            nack <= sda_s;
          end else if (scl_fall) begin
            if (nack) begin
              state <= ST_IDLE;
            end else begin
              tx       <= rd_data;
              sda_pd_o <= ~rd_data[DW-1];
              cnt      <= '0;
              state    <= ST_RD;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cfg_chk.sv
module i2c_cfg_chk
  import i2c_cfg_pkg::*;
#(
  parameter int unsigned NREG = 16,
  parameter int unsigned DW   = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               scl_s,
  input logic               sda_pd,
  input st_e                state,
  input logic [NREG*DW-1:0] regs
);
  assert_pull_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pd) |-> !scl_s);

  assert_ack_held_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state == ST_DEV_ACK || state == ST_WR_ACK) && scl_s) |-> sda_pd);

  assert_idle_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> !sda_pd);

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |=> $stable(regs));

  assert_write_at_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs) |-> sda_pd);
endmodule

bind i2c_cfg_slave i2c_cfg_chk #(.NREG(NREG), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .sda_pd(sda_pd_o),
  .state(state), .regs(regs_o)
);

// File: tb/tb_i2c_cfg_slave.sv
module tb_i2c_cfg_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, asel = 1'b1;
  logic sda_bus;
  logic [127:0] regs;
  logic sda_pd;
  int checks = 0, errs = 0;
  logic [7:0] model [16];
  int mptr = 0;
  logic viol = 1'b0;
  logic scl_prev = 1'b1, pd_prev = 1'b0;
  bit done = 0;

  localparam int Q = 5;
  localparam logic [15:0] VEC [8] = '{16'h00A5, 16'h0F3C, 16'h075A, 16'h0801,
                                      16'h0AFF, 16'h0280, 16'h0C96, 16'h0E00};

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pd;

  i2c_cfg_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel_i(asel), .regs_o(regs), .sda_pd_o(sda_pd)
  );

  // R10 port monitor: pull-down must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n && scl_m && scl_prev && sda_pd !== pd_prev) viol = 1'b1;
    scl_prev = scl_m;
    pd_prev  = sda_pd;
  end

  task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; wt(Q); scl_m = 1; wt(Q); sda_m = 0; wt(Q); scl_m = 0; wt(Q); endtask
  task automatic bus_stop(); sda_m = 0; wt(Q); scl_m = 1; wt(Q); sda_m = 1; wt(Q); endtask
  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; wt(Q); scl_m = 1; wt(Q); s = sda_bus; wt(Q); scl_m = 0; wt(Q);
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask
  task automatic send_bits(input logic [7:0] b, input int n);
    logic s;
    for (int i = 7; i > 7 - n; i--) clk_bit(b[i], s);
    sda_m = 1; wt(Q);
  endtask
  task automatic recv_byte(output logic [7:0] b, input logic mack);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
    clk_bit(!mack, s);
  endtask
  task automatic dev(input logic rw, output logic ack);
    send_byte({4'b1011, asel, 2'b00, rw}, ack);
  endtask

  task automatic wr_one(input logic [7:0] p, input logic [7:0] d);
    logic a;
    bus_start(); dev(0, a); send_byte(p, a); send_byte(d, a); bus_stop();
    model[p[3:0]] = d; mptr = (p[3:0] + 1) % 16;
  endtask
  task automatic rd_at(input logic [7:0] p, output logic [7:0] d);
    logic a;
    bus_start(); dev(0, a); send_byte(p, a);
    bus_start(); dev(1, a); recv_byte(d, 0); bus_stop();
    mptr = (p[3:0] + 1) % 16;
  endtask

  task automatic check_image(input string req);
    logic [127:0] e;
    for (int k = 0; k < 16; k++) e[k*8 +: 8] = model[k];
    chk(regs === e, req, regs, e);
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    logic s;
    logic bad;
    for (int k = 0; k < 16; k++) model[k] = 8'h00;
    wt(5); rst_n = 1; wt(3);
    chk(regs === '0, "R9 reset image", regs, '0);
    chk(sda_pd === 1'b0, "R9 reset sda", sda_pd, 0);

    // R1 address with strap high
    bus_start(); dev(0, a); bus_stop();
    chk(a === 1'b1, "R1 ack strap=1", a, 1);

    // R3 / R7 vector table: write then random read
    foreach (VEC[i]) begin
      wr_one(VEC[i][15:8], VEC[i][7:0]);
      chk(regs[VEC[i][11:8]*8 +: 8] === VEC[i][7:0], "R3 image slice", regs[VEC[i][11:8]*8 +: 8], VEC[i][7:0]);
      rd_at(VEC[i][15:8], d);
      chk(d === VEC[i][7:0], "R7 random read", d, VEC[i][7:0]);
    end

    // R2 wrong strap level and general call
    bus_start(); send_byte(8'hB0, a); send_byte(8'h01, a); send_byte(8'h77, a); bus_stop();
    chk(a === 1'b0, "R2 strap mismatch no ack", a, 0);
    check_image("R2 image unchanged");
    bus_start(); send_byte(8'h00, a); send_byte(8'h02, a); bus_stop();
    chk(a === 1'b0, "R2 general call no ack", a, 0);
    check_image("R2 image after general call");

    // R1 strap low
    asel = 0; wt(2);
    bus_start(); send_byte(8'hB8, a); bus_stop();
    chk(a === 1'b0, "R2 old address with strap=0", a, 0);
    bus_start(); dev(0, a); bus_stop();
    chk(a === 1'b1, "R1 ack strap=0", a, 1);
    asel = 1; wt(2);

    // R4 / R5 sequential write from 14, 18 bytes, wraps
    bus_start(); dev(0, a); send_byte(8'h0E, a);
    mptr = 14;
    for (int i = 0; i < 18; i++) begin
      send_byte(8'h30 + 8'(i), a);
      model[mptr] = 8'h30 + 8'(i);
      if (i == 0)
        chk(regs[14*8 +: 8] === 8'h30, "R5 stored before STOP", regs[14*8 +: 8], 8'h30);
      mptr = (mptr + 1) % 16;
    end
    bus_stop();
    check_image("R4 wrap overwrite image");
    chk(regs[14*8 +: 8] === 8'h40, "R4 reg14 rewritten", regs[14*8 +: 8], 8'h40);

    // R6 partial byte then STOP
    bus_start(); dev(0, a); send_byte(8'h03, a); send_byte(8'h11, a); send_bits(8'hEE, 4); bus_stop();
    model[3] = 8'h11;
    check_image("R6 partial on STOP");
    // R6 partial byte then repeated START
    bus_start(); dev(0, a); send_byte(8'h05, a); send_bits(8'h5A, 5);
    bus_start(); dev(0, a); bus_stop();
    check_image("R6 partial on repeated START");

    // R7 sequential read from 13, wraps
    bus_start(); dev(0, a); send_byte(8'h0D, a);
    bus_start(); dev(1, a);
    for (int i = 0; i < 5; i++) begin
      recv_byte(d, i != 4);
      chk(d === model[(13 + i) % 16], "R7 sequential read wrap", d, model[(13 + i) % 16]);
    end
    // R8 after NACK the slave stays silent
    bad = 0;
    for (int i = 0; i < 9; i++) begin clk_bit(1'b1, s); if (!s) bad = 1; end
    chk(bad === 1'b0, "R8 released after NACK", bad, 0);
    bus_stop();

    chk(viol === 1'b0, "R10 no SDA change while SCL high", viol, 0);

    // R9 reset clears written image
    rst_n = 0; wt(3);
    chk(regs === '0, "R9 image cleared", regs, '0);
    rst_n = 1; wt(3);
    chk(sda_pd === 1'b0, "R9 sda released", sda_pd, 0);

    summary();
  end
endmodule